// File: doc/BRIEF.md
# Register-Driven Multiply-Accumulate Unit

This block is a 16x16 multiplier with a 48-bit accumulator, controlled entirely through a small register bus. Software writes a control word, then loads operand registers. The operation is launched once the configured number of operand writes has arrived. It stores the product, stores the negated product, adds the product to the accumulator or subtracts it from the accumulator. Products are treated as signed two's-complement or unsigned numbers. Signed products are sign-extended to the accumulator width before they are used.

The result lands one clock after the launching write. A write-inhibit bit keeps the accumulator untouched while a 32-bit read-only shadow still captures a result. An overflow flag follows carry and sign rules. A self-clearing clear bit resets the operands, the accumulator, the flag and the operand tracking. The accumulator words can also be loaded directly over the bus.

Top module: `mac_unit`

## Requirements
- R1: After reset, every readable address (0 control, 1 operand A, 2 operand B, 3 to 5 accumulator low to high word, 6 and 7 shadow low and high word) reads zero.
- R2: With control bits [1] and [2] both 0, an operation is launched only once both operand A (address 1) and operand B (address 2) have been written. Rewriting the same operand does not launch it. The write tracking returns to empty after each launch.
- R3: With control bit [1] (single operand) set, a write to either operand register launches the operation using the current value of the other register.
- R4: With control bit [2] (square) set, a write to either operand register loads both registers and launches at once, whatever bit [1] holds.
- R5: With control bit [3] (accumulate) clear, the accumulator receives the product when bit [4] (subtract) is 0 and the negated product when bit [4] is 1. Bit [0] set means unsigned operands; clear means signed operands, with the product sign-extended to 48 bits.
- R6: With control bit [3] set, the product is added to the accumulator when bit [4] is 0, and subtracted from it when bit [4] is 1.
- R7: With control bit [5] (write inhibit) set, an operation leaves the accumulator unchanged.
- R8: The 32-bit shadow at addresses 6 and 7 updates on every operation. When accumulating with writes enabled, it holds the low 32 bits of the product, negated when subtracting. Otherwise it holds the low 32 bits of the result that would be stored.
- R9: In unsigned accumulate or subtract, the overflow flag (control read bit [7]) is set exactly when a carry-out or borrow occurs at the accumulator MSB.
- R10: In signed accumulate or subtract, the overflow flag is set exactly when the true result falls outside the 48-bit two's-complement range.
- R11: A store or negate operation clears the overflow flag, except that an unsigned negate sets it.
- R12: Writing control bit [6] (clear) zeroes both operands, the accumulator and the overflow flag, and empties the operand write tracking. Bit [6] always reads back 0.
- R13: The three accumulator words are writable over the bus. Changing control bit [0] leaves the accumulator contents unchanged.
- R14: The accumulator and shadow reflect the result after the first clock edge following the edge that captures the launching operand write, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle while high |
| rdata_o | output | 16 | Read data for the addressed register, combinational |

## Verification
A corrupted operand-tracking state shows at the ports as a launch that happens one write early or never happens. This shows up as a wrong accumulator value on the read right after the suspect write. A wrong carry or sign decision in the adder shows as a flipped overflow bit on the next control read. The near-exhaustive sweep over boundary operands and boundary accumulator start values makes such errors visible within a single operation. A latency fault is caught by sampling the accumulator in the half cycle between the capturing edge and the result edge.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic inh;     // [5] block accumulator write
    logic sub;     // [4] subtract / negate
    logic acc_en;  // [3] accumulate
    logic square;  // [2] square mode
    logic one_op;  // [1] single operand launch
    logic uns;     // [0] unsigned operands
  } mac_ctrl_t;

  localparam int unsigned CTRL_W      = 6;
  localparam int unsigned CLR_BIT     = 6;
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_OPA    = 1;
  localparam int unsigned ADDR_OPB    = 2;
  localparam int unsigned ADDR_ACC0   = 3;
  localparam int unsigned SH_WORDS    = 2;
endpackage

// File: rtl/mac_opseq.sv
module mac_opseq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic       one_op_i,
  input  logic       square_i,
  output logic       fire_o,
  output logic [1:0] seen_o
);
  logic a_seen_q, b_seen_q;

  assign fire_o = (wr_a_i || wr_b_i) &&
                  (one_op_i || square_i || (wr_a_i && b_seen_q) || (wr_b_i && a_seen_q));
  assign seen_o = {b_seen_q, a_seen_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_seen_q <= 1'b0;
      b_seen_q <= 1'b0;
    end else if (clr_i || fire_o) begin
      a_seen_q <= 1'b0;
      b_seen_q <= 1'b0;
    end else begin
      a_seen_q <= a_seen_q | wr_a_i;
      b_seen_q <= b_seen_q | wr_b_i;
    end
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 48,
  parameter int unsigned SH_W  = 32
) (
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  mac_ctrl_t        ctrl_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] res_o,
  output logic [SH_W-1:0]  sh_o,
  output logic             ovf_o
);
  localparam int unsigned PW = 2 * OP_W;
  localparam int unsigned M  = ACC_W - 1;

  logic [PW-1:0]    prod_u, prod_s;
  logic [ACC_W-1:0] prod_e, addend, sum;
  logic [ACC_W:0]   ext;
  logic             s_ovf;

  assign prod_u = {{OP_W{1'b0}}, op_a_i} * {{OP_W{1'b0}}, op_b_i};
  assign prod_s = $signed({{OP_W{op_a_i[OP_W-1]}}, op_a_i}) *
                  $signed({{OP_W{op_b_i[OP_W-1]}}, op_b_i});

  assign prod_e = ctrl_i.uns ? {{(ACC_W-PW){1'b0}}, prod_u}
                             : {{(ACC_W-PW){prod_s[PW-1]}}, prod_s};
  assign addend = ctrl_i.sub ? (~prod_e + 1'b1) : prod_e;

  // one adder, top bit carries the unsigned carry or borrow
  assign ext = ctrl_i.sub ? ({1'b0, acc_i} - {1'b0, prod_e})
                          : ({1'b0, acc_i} + {1'b0, prod_e});
  assign sum = ext[ACC_W-1:0];

  assign s_ovf = ctrl_i.sub ? ((acc_i[M] != prod_e[M]) && (sum[M] != acc_i[M]))
                            : ((acc_i[M] == prod_e[M]) && (sum[M] != acc_i[M]));

  always_comb begin
    if (ctrl_i.acc_en) begin
      res_o = sum;
      ovf_o = ctrl_i.uns ? ext[ACC_W] : s_ovf;
    end else begin
      res_o = addend;
      ovf_o = ctrl_i.sub && ctrl_i.uns;
    end
    sh_o = (ctrl_i.acc_en && !ctrl_i.inh) ? addend[SH_W-1:0] : res_o[SH_W-1:0];
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter  int unsigned OP_W      = 16,
  parameter  int unsigned ACC_WORDS = 3,
  localparam int unsigned N_REGS    = ADDR_ACC0 + ACC_WORDS + SH_WORDS,
  localparam int unsigned AW        = $clog2(N_REGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [OP_W-1:0] wdata_i,
  input  logic            we_i,
  output logic [OP_W-1:0] rdata_o
);
  localparam int unsigned ACC_W   = OP_W * ACC_WORDS;
  localparam int unsigned SH_W    = OP_W * SH_WORDS;
  localparam int unsigned ADDR_SH = ADDR_ACC0 + ACC_WORDS;

  mac_ctrl_t        ctrl_q;
  logic [OP_W-1:0]  opa_q, opb_q;
  logic [ACC_W-1:0] acc_q, res;
  logic [SH_W-1:0]  sh_q, sh_n;
  logic             ovf_q, ovf_n, pend_q, fire;
  logic [1:0]       seen;
  logic             wr_ctrl, wr_a, wr_b, clr;
  logic [OP_W-1:0]  acc_w [ACC_WORDS];
  logic [OP_W-1:0]  sh_w  [SH_WORDS];

  assign wr_ctrl = we_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_a    = we_i && (addr_i == AW'(ADDR_OPA));
  assign wr_b    = we_i && (addr_i == AW'(ADDR_OPB));
  assign clr     = wr_ctrl && wdata_i[CLR_BIT];

  mac_opseq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .wr_a_i   (wr_a),
    .wr_b_i   (wr_b),
    .one_op_i (ctrl_q.one_op),
    .square_i (ctrl_q.square),
    .fire_o   (fire),
    .seen_o   (seen)
  );

  mac_arith #(.OP_W(OP_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_arith (
    .op_a_i (opa_q),
    .op_b_i (opb_q),
    .ctrl_i (ctrl_q),
    .acc_i  (acc_q),
    .res_o  (res),
    .sh_o   (sh_n),
    .ovf_o  (ovf_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      acc_q  <= '0;
      sh_q   <= '0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= fire;
      if (wr_ctrl) ctrl_q <= mac_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (clr) begin
        opa_q  <= '0;
        opb_q  <= '0;
        acc_q  <= '0;
        ovf_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (wr_a) begin
          opa_q <= wdata_i;
          if (ctrl_q.square) opb_q <= wdata_i;
        end
        if (wr_b) begin
          opb_q <= wdata_i;
          if (ctrl_q.square) opa_q <= wdata_i;
        end
        for (int k = 0; k < ACC_WORDS; k++)
          if (we_i && (addr_i == AW'(ADDR_ACC0 + k))) acc_q[k*OP_W +: OP_W] <= wdata_i;
        // launched result overrides a same-cycle bus write
        if (pend_q) begin
          if (!ctrl_q.inh) acc_q <= res;
          ovf_q <= ovf_n;
          sh_q  <= sh_n;
        end
      end
    end
  end

  for (genvar g = 0; g < ACC_WORDS; g++) begin : g_accw
    assign acc_w[g] = acc_q[g*OP_W +: OP_W];
  end
  for (genvar g = 0; g < SH_WORDS; g++) begin : g_shw
    assign sh_w[g] = sh_q[g*OP_W +: OP_W];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTRL)) rdata_o = OP_W'({ovf_q, 1'b0, ctrl_q});
    if (addr_i == AW'(ADDR_OPA))  rdata_o = opa_q;
    if (addr_i == AW'(ADDR_OPB))  rdata_o = opb_q;
    for (int k = 0; k < ACC_WORDS; k++)
      if (addr_i == AW'(ADDR_ACC0 + k)) rdata_o = acc_w[k];
    for (int k = 0; k < SH_WORDS; k++)
      if (addr_i == AW'(ADDR_SH + k)) rdata_o = sh_w[k];
  end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int unsigned OP_W      = 16,
  parameter int unsigned ACC_WORDS = 3,
  parameter int unsigned AW        = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [AW-1:0]             addr_i,
  input logic [OP_W-1:0]           wdata_i,
  input logic                      we_i,
  input logic                      fire_i,
  input logic                      pend_i,
  input logic [1:0]                seen_i,
  input mac_ctrl_t                 ctrl_i,
  input logic [OP_W*ACC_WORDS-1:0] acc_i,
  input logic                      ovf_i,
  input logic [OP_W-1:0]           opa_i,
  input logic [OP_W-1:0]           opb_i
);
  logic wr_a, wr_b, clr, acc_bus;
  assign wr_a    = we_i && (addr_i == AW'(ADDR_OPA));
  assign wr_b    = we_i && (addr_i == AW'(ADDR_OPB));
  assign clr     = we_i && (addr_i == AW'(ADDR_CTRL)) && wdata_i[CLR_BIT];
  assign acc_bus = we_i && (addr_i >= AW'(ADDR_ACC0)) && (addr_i < AW'(ADDR_ACC0 + ACC_WORDS));

  // R12
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (acc_i == '0 && !ovf_i && opa_i == '0 && opb_i == '0 && seen_i == 2'b00 && !pend_i));

  // R7
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && ctrl_i.inh && !clr && !acc_bus) |=> $stable(acc_i));

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !ctrl_i.acc_en && !ctrl_i.sub && !clr) |=> !ovf_i);

  // R11
  uns_negate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !ctrl_i.acc_en && ctrl_i.sub && ctrl_i.uns && !clr) |=> ovf_i);

  // R2
  rewrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.one_op && !ctrl_i.square && seen_i == 2'b01 && wr_a) |-> !fire_i);

  // R2
  track_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (seen_i == 2'b00));

  // R3
  single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_i.one_op || ctrl_i.square) && (wr_a || wr_b)) |-> fire_i);

  // R14
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !clr) |=> pend_i);
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_WORDS(ACC_WORDS), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .fire_i  (fire),
  .pend_i  (pend_q),
  .seen_i  (seen),
  .ctrl_i  (ctrl_q),
  .acc_i   (acc_q),
  .ovf_i   (ovf_q),
  .opa_i   (opa_q),
  .opb_i   (opb_q)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mac_unit u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .addr_i  (addr),
    .wdata_i (wdata),
    .we_i    (we),
    .rdata_o (rdata)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_acc(output logic [47:0] v);
    logic [15:0] w0, w1, w2;
    rd(3, w0); rd(4, w1); rd(5, w2);
    v = {w2, w1, w0};
  endtask

  task automatic rd_sh(output logic [31:0] v);
    logic [15:0] w0, w1;
    rd(6, w0); rd(7, w1);
    v = {w1, w0};
  endtask

  task automatic set_acc(input logic [47:0] v);
    wr(3, v[15:0]); wr(4, v[31:16]); wr(5, v[47:32]);
  endtask

  // expected values from plain integer arithmetic
  function automatic void model(input logic [5:0] c, input logic [47:0] acc,
                                input logic [15:0] a, input logic [15:0] b,
                                output logic [47:0] acc_n, output logic [31:0] sh,
                                output bit ovf);
    bit uns, acc_en, sub, inh;
    longint p, av, r, add;
    uns = c[0]; acc_en = c[3]; sub = c[4]; inh = c[5];
    p  = uns ? longint'(a) * longint'(b) : longint'($signed(a)) * longint'($signed(b));
    av = uns ? longint'(acc) : longint'($signed(acc));
    if (acc_en) begin
      r   = sub ? av - p : av + p;
      add = sub ? -p : p;
      if (uns) ovf = (r < 0) || (r > (longint'(1) <<< 48) - 1);
      else     ovf = (r < -(longint'(1) <<< 47)) || (r > (longint'(1) <<< 47) - 1);
      sh = inh ? r[31:0] : add[31:0];
    end else begin
      r   = sub ? -p : p;
      ovf = sub && uns;
      sh  = r[31:0];
    end
    acc_n = inh ? acc : r[47:0];
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [47:0] acc, exp_acc, st;
    logic [31:0] sh, exp_sh;
    bit          exp_ovf;
    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [47:0] starts [5] = '{48'h0, 48'h7FFF_FFFF_FFFF, 48'h8000_0000_0000,
                                48'hFFFF_FFFF_FFFF, 48'h0000_1234_5678};

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), d);
      check("R1 reset read", d, 0);
    end

    // R2 two-operand launch, rewrite does not launch
    wr(0, 16'h0000);
    wr(1, 16'd3);
    rd_acc(acc); check("R2 no launch after A", acc, 0);
    wr(1, 16'd5);
    rd_acc(acc); check("R2 no launch on rewrite of A", acc, 0);
    wr(2, 16'd7);
    rd_acc(acc); check("R2 launch on B", acc, 35);
    wr(2, 16'd2);
    rd_acc(acc); check("R2 tracking emptied after launch", acc, 35);
    wr(0, 16'h0040);

    // R4 square, operand count bit ignored
    wr(0, 16'h0004);
    wr(1, 16'hFFFD);
    rd(2, d); check("R4 square loads B", d, 16'hFFFD);
    rd_acc(acc); check("R4 square result", acc, 9);
    wr(2, 16'h0006);
    rd(1, d); check("R4 square loads A", d, 16'h0006);
    rd_acc(acc); check("R4 square via B", acc, 36);

    // R3 single operand
    wr(0, 16'h0002);
    wr(2, 16'h0004);
    rd_acc(acc); check("R3 launch on B alone", acc, 48'h0000_0000_0018);
    wr(1, 16'hFFFD);
    rd_acc(acc); check("R3 launch on A alone, signed", acc, 48'hFFFF_FFFF_FFF4);

    // R12 clear: set overflow first with unsigned negate
    wr(0, 16'h0011);
    wr(1, 16'd2); wr(2, 16'd3);
    rd(0, d); check("R11 unsigned negate sets flag", d[7], 1);
    wr(0, 16'h0000);
    wr(1, 16'd9);
    wr(0, 16'h0040);
    rd(0, d); check("R12 control after clear", d, 0);
    rd(1, d); check("R12 A cleared", d, 0);
    rd(2, d); check("R12 B cleared", d, 0);
    rd_acc(acc); check("R12 acc cleared", acc, 0);
    wr(2, 16'd6);
    rd_acc(acc); check("R12 tracking emptied", acc, 0);
    wr(1, 16'd4);
    rd_acc(acc); check("R12 launch after clear", acc, 24);

    // R14 latency
    wr(1, 16'd2);
    wr(2, 16'd8);
    addr = 3'd3;
    #1 check("R14 not yet updated", rdata, 24);
    rd_acc(acc); check("R14 updated next edge", acc, 16);

    // R13 direct load, type change keeps acc
    set_acc(48'hAAAA_5555_1234);
    rd_acc(acc); check("R13 bus load", acc, 48'hAAAA_5555_1234);
    wr(0, 16'h0001);
    rd_acc(acc); check("R13 unsigned select keeps acc", acc, 48'hAAAA_5555_1234);
    wr(0, 16'h0000);
    rd_acc(acc); check("R13 signed select keeps acc", acc, 48'hAAAA_5555_1234);

    // sweep: signedness, accumulate, subtract, inhibit
    for (int m = 0; m < 16; m++) begin
      logic [5:0] c;
      c = {m[3], m[2], m[1], 2'b00, m[0]};
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          st = starts[(i + j + m) % 5];
          set_acc(st);
          wr(0, {10'b0, c});
          wr(1, vals[i]);
          wr(2, vals[j]);
          model(c, st, vals[i], vals[j], exp_acc, exp_sh, exp_ovf);
          rd_acc(acc);
          if (c[5])      check("R7 inhibit acc", acc, exp_acc);
          else if (c[3]) check("R6 accumulate", acc, exp_acc);
          else           check("R5 store", acc, exp_acc);
          rd_sh(sh);
          check("R8 shadow", sh, exp_sh);
          rd(0, d);
          if (!c[3])     check("R11 flag", d[7], exp_ovf);
          else if (c[0]) check("R9 unsigned flag", d[7], exp_ovf);
          else           check("R10 signed flag", d[7], exp_ovf);
        end
      end
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule